// File: doc/BRIEF.md
# PWM Phase Timebase

This block is the common timebase for a bank of pulse-width modulation channels. A beat divider splits the core clock into beats. Each beat is one core clock wide and comes once every `div + 1` clocks. On every beat a 16-bit phase accumulator moves forward by a power-of-two step that a resolution setting chooses. The step is 2^(15 - resolution), so one PWM period holds 2^(resolution + 1) beats. The period ends when the accumulator wraps back to zero, and a strobe marks that beat.

Every channel comparator reads the phase output. The beat and cycle-end strobes let neighbouring logic update its state at beat or period boundaries. The enable controls the whole timebase. While the enable is low, the divider and the accumulator are held at zero, and the divider and resolution inputs are sampled into shadow registers. While the enable is high, those shadow registers are frozen, so the period cannot change in the middle of a run. Counting starts one clock after the enable rises.

Top module: `pwm_phase_timer`

## Requirements
- R1: After reset, `phase` is 0 and `beat` and `cycle_end` are low.
- R2: While running, `beat` is high for exactly one clock out of every `div + 1` clocks, where `div` is the value captured before the run.
- R3: On each beat, `phase` advances by 2^(15 - `resn`) modulo 65536 in the clock that follows. `resn` is the 4-bit value captured before the run; for example, `resn` = 10 gives a step of 0x0020.
- R4: `cycle_end` is high only together with `beat`, on the beat after which `phase` wraps to 0. This happens every 2^(`resn` + 1) beats.
- R5: A clock edge that samples `cnt_en` low clears `phase` and the divider. It also forces `beat` and `cycle_end` low from that edge until counting restarts.
- R6: Changes to `div_cfg` and `resn_cfg` while `cnt_en` is high have no effect on the current run. They only take effect for a run that starts after the enable has been low.
- R7: The first edge that samples `cnt_en` high only arms the counter. The divider count is 0 after that edge, so the first beat appears `div` clocks later.
- R8: Between beats, `phase` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timebase run enable |
| div_cfg | input | 16 | Beat divider value; beat period is div_cfg+1 clocks |
| resn_cfg | input | 4 | Resolution; step is 2^(15-resn_cfg) |
| phase | output | 16 | Shared phase count |
| beat | output | 1 | One-clock strobe on the last divider count |
| cycle_end | output | 1 | One-clock strobe on the beat that wraps phase to 0 |

## Verification
The bench builds the block with its default parameters: a 16-bit phase and a 16-bit divider. It then runs four divider/resolution pairs: 0/15, 0/0, 2/10 and 4/3. The pairs 0/0 and 4/3 give short periods of 2 and 16 beats, so several phase wraps and cycle-end strobes fall inside a short run. The 0/15 pair exercises a step of 1 with a beat on every clock. The 2/10 pair changes its inputs partway through the run to show they are held off. Each run ends with a disable, which shows the clear.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int unsigned PHASE_W = 16;
  localparam int unsigned RESN_W  = $clog2(PHASE_W);

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [RESN_W-1:0]  resn_t;

  // Per-beat increment: 2^(PHASE_W-1-resn)
  function automatic phase_t step_of(input resn_t resn);
    phase_t s;
    s = '0;
    s[PHASE_W-1-int'(resn)] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/pwm_cfg_hold.sv
module pwm_cfg_hold #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned RESN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [RESN_W-1:0] resn_in,
  output logic [DIV_W-1:0]  div_q,
  output logic [RESN_W-1:0] resn_q,
  output logic              run
);
  logic              armed_q, armed_d;
  logic              cap_en;
  logic [DIV_W-1:0]  div_d;
  logic [RESN_W-1:0] resn_d;

  always_comb begin
    cap_en  = ~cnt_en;
    armed_d = cnt_en;
    div_d   = cap_en ? div_in  : div_q;
    resn_d  = cap_en ? resn_in : resn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      div_q   <= '0;
      resn_q  <= '0;
    end else begin
      armed_q <= armed_d;
      div_q   <= div_d;
      resn_q  <= resn_d;
    end
  end

  assign run = cnt_en & armed_q;
endmodule

// File: rtl/pwm_beat_div.sv
module pwm_beat_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lim,
  output logic             beat
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  always_comb begin
    at_lim = (cnt_q == div_lim);
    beat   = run & at_lim;
    if (!run)        cnt_d = '0;
    else if (at_lim) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
  import pwm_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   beat,
  input  resn_t  resn,
  output phase_t phase_q,
  output logic   wrap
);
  phase_t phase_d, sum;
  logic   adv_en;

  always_comb begin
    sum    = phase_q + step_of(resn);
    adv_en = beat;
    wrap   = beat & (sum == '0);
    if (!run)        phase_d = '0;
    else if (adv_en) phase_d = sum;
    else             phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_phase_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic [DIV_W-1:0]    div_cfg,
  input  logic [RESN_W-1:0]   resn_cfg,
  output logic [PHASE_W-1:0]  phase,
  output logic                beat,
  output logic                cycle_end
);
  logic              run;
  logic [DIV_W-1:0]  div_lim;
  resn_t             resn_lat;

  pwm_cfg_hold #(.DIV_W(DIV_W), .RESN_W(RESN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
    .div_in(div_cfg), .resn_in(resn_cfg),
    .div_q(div_lim), .resn_q(resn_lat), .run(run)
  );

  pwm_beat_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div_lim(div_lim), .beat(beat)
  );

  pwm_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .run(run), .beat(beat), .resn(resn_lat),
    .phase_q(phase), .wrap(cycle_end)
  );
endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk
  import pwm_phase_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_en,
  input logic [PHASE_W-1:0] phase,
  input logic               beat,
  input logic               cycle_end
);
  // R5
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (phase == '0 && !beat && !cycle_end));
  // R4
  end_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |-> beat);
  // R4
  end_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && cnt_en) |=> phase == '0);
  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && cnt_en) |=> $stable(phase));
  // R3
  beat_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cnt_en) |=> !$stable(phase));
endmodule

bind pwm_phase_timer pwm_phase_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
  .phase(phase), .beat(beat), .cycle_end(cycle_end)
);

// File: tb/pwm_phase_timer_bench.sv
module pwm_phase_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic [15:0] div_cfg;
  logic [3:0]  resn_cfg;
  logic [15:0] phase;
  logic        beat;
  logic        cycle_end;
  int          n_chk;
  int          n_bad;

  pwm_phase_timer u_pwm_phase_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div_cfg(div_cfg),
    .resn_cfg(resn_cfg), .phase(phase), .beat(beat), .cycle_end(cycle_end)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Run one enable period with captured div/resn; optionally disturb the inputs mid-run.
  task automatic scenario(input int d, input int r, input int nclk, input bit disturb);
    longint step, k, idx;
    cnt_en = 1'b0; div_cfg = 16'(d); resn_cfg = 4'(r);
    repeat (2) @(negedge clk);
    cnt_en = 1'b1;
    step = longint'(1) << (15 - r);
    for (int t = 1; t <= nclk; t++) begin
      @(posedge clk); @(negedge clk);
      if (disturb && t == nclk / 2) begin
        div_cfg = 16'(d + 3); resn_cfg = 4'(r ^ 5);
      end
      idx = (t - 1) % (d + 1);
      k   = (t - 1) / (d + 1);
      // R7 (start latency folded into t-1), R2, R6 (old values kept)
      check(disturb ? "R6 beat" : "R2 beat", beat, idx == d);
      // R3, R8, R6
      check(disturb ? "R6 phase" : "R3 phase", phase, (k * step) % 65536);
      // R4
      check("R4 cycle_end", cycle_end, (idx == d) && (((k + 1) * step) % 65536 == 0));
    end
    cnt_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 phase clear", phase, 0);
    check("R5 beat low", beat, 0);
    check("R5 end low", cycle_end, 0);
  endtask

  task automatic test_reset();
    check("R1 phase", phase, 0);
    check("R1 beat", beat, 0);
    check("R1 end", cycle_end, 0);
  endtask

  task automatic test_first_beat();
    // R7: divider 5, first beat 5 clocks after the arming edge
    cnt_en = 1'b0; div_cfg = 16'd5; resn_cfg = 4'd15;
    repeat (2) @(negedge clk);
    cnt_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 no beat at arm", beat, 0);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    check("R7 first beat", beat, 1);
    check("R7 phase before step", phase, 0);
    @(posedge clk); @(negedge clk);
    check("R7 phase after step", phase, 1);
    cnt_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 clear after R7", phase, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cnt_en = 1'b0; div_cfg = '0; resn_cfg = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    scenario(0, 15, 40, 1'b0);
    scenario(0, 0, 12, 1'b0);
    scenario(4, 3, 170, 1'b0);
    scenario(2, 10, 200, 1'b1);
    test_first_beat();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule